// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block turns an asynchronous serial line into characters. A baud generator outside the block supplies a one-cycle strobe sixteen times per bit. The line input first passes through a two-flop synchroniser. The receiver then looks for a falling edge and confirms a start bit at its middle. It collects the data bits least significant bit first and checks an optional parity bit. It then checks one stop bit. Each finished character goes out as a single-cycle push, with its data byte and three flags: parity error, framing error and break. A downstream buffer takes the push.

Two line conditions get special handling. If a character with some nonzero bit ends on a low stop bit, the receiver looks at the line again half a bit later. If the line is still low, the receiver treats that moment as a new start edge. This lets it lock onto a following frame whose start bit joins the bad stop bit. If every bit of the frame is low, stop bit included, the receiver delivers a zero byte flagged as break. It then stops hunting until the line has been seen high on two consecutive oversample strobes.

Command pulses turn the receiver on, turn it off or reset it. Leaving the enabled state throws away any partly received character.

Top module: `serial_rx_top`

## Requirements
- R1: After `rstN` or a `cmdReset` pulse the receiver is off, with `pushValid` low, and frames on the line produce no push until a `cmdEnable` pulse. `cmdReset` and `cmdDisable` both win over a `cmdEnable` in the same cycle.
- R2: A falling edge starts a candidate start bit. The line is looked at again on the 8th oversample strobe after the strobe that saw the edge. If it is high then, the candidate is dropped with no push and hunting resumes.
- R3: The data length comes from `dataBits`: 0 selects 5 bits, 1 selects 6, 2 selects 7 and 3 selects 8. Bit 0 arrives first and lands in `pushData[0]`. Byte bits above the selected length are zero.
- R4: With `parityEn` high, one parity bit follows the data. `parityOdd` = 0 means the data bits plus the parity bit hold an even number of ones, and 1 means an odd number. A mismatch sets `pushParErr`. With `parityEn` low, `pushParErr` is always 0.
- R5: After a high stop bit the receiver hunts at once, so frames sent back to back with no idle time between them are all received.
- R6: A low stop bit on a frame with at least one high data or parity bit sets `pushFrmErr`. If the line is still low 8 strobes after the stop sample, that point counts as a start edge, so a frame whose start bit follows the bad stop bit directly is still received correctly.
- R7: A frame that is low in every bit, stop included, is delivered as `pushData` = 0 with `pushBreak` = 1 and `pushFrmErr` = `pushParErr` = 0.
- R8: After a break the line may stay low for any time without further pushes. Hunting resumes only after two consecutive strobes see the line high.
- R9: `pushValid` is high for exactly one clock per character. Data and all flags are valid in that same cycle.
- R10: A `cmdDisable` pulse during a character drops it, with no push. After a later `cmdEnable` the next frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleTick | input | 1 | Oversample strobe, 16 per bit time |
| cmdEnable | input | 1 | Pulse: start hunting for characters |
| cmdDisable | input | 1 | Pulse: stop and drop any partial character |
| cmdReset | input | 1 | Pulse: return to the off state |
| dataBits | input | 2 | Data length code (0..3 selects 5..8 bits) |
| parityEn | input | 1 | Expect a parity bit |
| parityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| lineIn | input | 1 | Asynchronous serial line, idle high |
| pushValid | output | 1 | One-cycle push strobe for a completed character |
| pushData | output | 8 | Received byte, upper bits zero for short lengths |
| pushParErr | output | 1 | Parity mismatch on this character |
| pushFrmErr | output | 1 | Stop bit was low on a non-break character |
| pushBreak | output | 1 | Character was a line break |

## Verification
A push is due one clock after the strobe that samples the middle of the stop bit. That is about 8 strobes into the stop bit, plus two synchroniser clocks, plus up to one strobe period of phase. A rejected start shows up as no push at all. Each task therefore drives whole bit times of 64 clocks and waits at least to the end of the stop bit before it reads anything. It then compares the pushes captured at falling clock edges, and their exact number, against values worked out from the requirement text. The bench counts the clocks that `pushValid` stays high to check the single-cycle pulse.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  typedef enum logic [2:0] {
    S_OFF,
    S_HUNT,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_RESYNC,
    S_BRKWAIT
  } rxState_t;

  typedef struct packed {
    logic clearShift;
    logic takeBit;
    logic takeParity;
    logic pushOk;
    logic pushFrm;
    logic pushBrk;
  } rxStrobe_t;

endpackage

// File: rtl/serial_rx_sync.sv
module serial_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic lineS
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= '1;
    else       chain <= {chain[STAGES-2:0], lineIn};
  end

  assign lineS = chain[STAGES-1];

endmodule

// File: rtl/serial_rx_ctrl.sv
module serial_rx_ctrl
  import serial_rx_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DW     = 8,
  parameter int BRK_HI = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleTick,
  input  logic                   lineS,
  input  logic                   cmdEnable,
  input  logic                   cmdDisable,
  input  logic                   cmdReset,
  input  logic [1:0]             dataBits,
  input  logic                   parityEn,
  input  logic                   dataZero,
  output rxStrobe_t              strobe,
  output logic [$clog2(DW)-1:0]  bitIdx
);

  localparam int CW       = $clog2(OSR);
  localparam int IW       = $clog2(DW);
  localparam int HW       = $clog2(BRK_HI + 1);
  localparam int MIN_BITS = 5;

  rxState_t        state, stateNxt;
  logic [CW-1:0]   cnt, cntNxt;
  logic [IW-1:0]   idxNxt;
  logic [HW-1:0]   hiCnt, hiNxt;
  logic            lastLine;
  logic [IW-1:0]   lastIdx;
  logic            midHit, fullHit, cmdStop;

  assign lastIdx = IW'(dataBits) + IW'(MIN_BITS - 1);
  assign midHit  = (cnt == CW'(OSR / 2 - 1));
  assign fullHit = (cnt == CW'(OSR - 1));
  assign cmdStop = cmdReset || cmdDisable;

  always_comb begin
    stateNxt = state;
    cntNxt   = cnt;
    idxNxt   = bitIdx;
    hiNxt    = hiCnt;
    strobe   = '0;
    if (sampleTick) begin
      unique case (state)
        S_HUNT: begin
          if (lastLine && !lineS) begin
            stateNxt          = S_START;
            cntNxt            = '0;
            strobe.clearShift = 1'b1;
          end
        end
        S_START: begin
          if (midHit) begin
            cntNxt = '0;
            idxNxt = '0;
            stateNxt = lineS ? S_HUNT : S_DATA;
          end else cntNxt = cnt + 1'b1;
        end
        S_DATA: begin
          if (fullHit) begin
            strobe.takeBit = 1'b1;
            cntNxt         = '0;
            if (bitIdx == lastIdx) stateNxt = parityEn ? S_PAR : S_STOP;
            else                   idxNxt   = bitIdx + 1'b1;
          end else cntNxt = cnt + 1'b1;
        end
        S_PAR: begin
          if (fullHit) begin
            strobe.takeParity = 1'b1;
            cntNxt            = '0;
            stateNxt          = S_STOP;
          end else cntNxt = cnt + 1'b1;
        end
        S_STOP: begin
          if (fullHit) begin
            cntNxt = '0;
            if (lineS) begin
              strobe.pushOk = 1'b1;
              stateNxt      = S_HUNT;
            end else if (dataZero) begin
              strobe.pushBrk = 1'b1;
              hiNxt          = '0;
              stateNxt       = S_BRKWAIT;
            end else begin
              strobe.pushFrm = 1'b1;
              stateNxt       = S_RESYNC;
            end
          end else cntNxt = cnt + 1'b1;
        end
        S_RESYNC: begin
          if (midHit) begin
            cntNxt = '0;
            if (!lineS) begin
              stateNxt          = S_START;
              strobe.clearShift = 1'b1;
            end else stateNxt = S_HUNT;
          end else cntNxt = cnt + 1'b1;
        end
        S_BRKWAIT: begin
          if (lineS) begin
            if (hiCnt == HW'(BRK_HI - 1)) stateNxt = S_HUNT;
            else                          hiNxt    = hiCnt + 1'b1;
          end else hiNxt = '0;
        end
        default: ;
      endcase
    end
    if (cmdStop) begin
      stateNxt = S_OFF;
      strobe   = '0;
    end else if (cmdEnable && state == S_OFF) begin
      stateNxt = S_HUNT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_OFF;
      cnt      <= '0;
      bitIdx   <= '0;
      hiCnt    <= '0;
      lastLine <= 1'b0;
    end else begin
      state  <= stateNxt;
      cnt    <= cntNxt;
      bitIdx <= idxNxt;
      hiCnt  <= hiNxt;
      if (sampleTick) lastLine <= lineS;
    end
  end

  // R10: stop commands always land in the off state
  p_cmd_off_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdStop |=> state == S_OFF);

  // R1: enable from off begins hunting
  p_enable_hunt_r1: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_OFF && cmdEnable && !cmdStop) |=> state == S_HUNT);

  // R3: bit index never exceeds configured length
  p_idx_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == S_DATA |-> bitIdx <= lastIdx);

  // R8: a low line keeps the break wait
  p_brk_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_BRKWAIT && sampleTick && !lineS && !cmdStop) |=> state == S_BRKWAIT);

endmodule

// File: rtl/serial_rx_dpath.sv
module serial_rx_dpath
  import serial_rx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  lineS,
  input  rxStrobe_t             strobe,
  input  logic [$clog2(DW)-1:0] bitIdx,
  input  logic [1:0]            dataBits,
  input  logic                  parityEn,
  input  logic                  parityOdd,
  output logic                  dataZero,
  output logic                  pushValid,
  output logic [DW-1:0]         pushData,
  output logic                  pushParErr,
  output logic                  pushFrmErr,
  output logic                  pushBreak
);

  logic [DW-1:0] shiftReg;
  logic          parBit;
  logic          parMismatch;
  logic          anyPush;

  assign dataZero    = (shiftReg == '0) && !(parityEn && parBit);
  assign parMismatch = parityEn && ((^shiftReg) ^ parBit ^ parityOdd);
  assign anyPush     = strobe.pushOk || strobe.pushFrm || strobe.pushBrk;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      parBit   <= 1'b0;
    end else begin
      if (strobe.clearShift) begin
        shiftReg <= '0;
        parBit   <= 1'b0;
      end
      if (strobe.takeBit)    shiftReg[bitIdx] <= lineS;
      if (strobe.takeParity) parBit           <= lineS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pushValid  <= 1'b0;
      pushData   <= '0;
      pushParErr <= 1'b0;
      pushFrmErr <= 1'b0;
      pushBreak  <= 1'b0;
    end else begin
      pushValid <= anyPush;
      if (anyPush) begin
        pushData   <= strobe.pushBrk ? '0 : shiftReg;
        pushParErr <= !strobe.pushBrk && parMismatch;
        pushFrmErr <= strobe.pushFrm;
        pushBreak  <= strobe.pushBrk;
      end
    end
  end

  // R9: each character is a single-cycle push
  p_push_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    pushValid |=> !pushValid);

  // R7: break characters carry no other flag and zero data
  p_brk_clean_r7: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && pushBreak) |-> (pushData == '0 && !pushFrmErr && !pushParErr));

  // R3: five-bit characters leave the upper byte bits clear
  p_upper_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && dataBits == 2'd0 && $stable(dataBits)) |-> pushData[DW-1:5] == '0);

  // R4: parity flag stays low with parity off
  p_no_par_r4: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !parityEn && $stable(parityEn)) |-> !pushParErr);

endmodule

// File: rtl/serial_rx_top.sv
module serial_rx_top
  import serial_rx_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int BRK_HI      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleTick,
  input  logic       cmdEnable,
  input  logic       cmdDisable,
  input  logic       cmdReset,
  input  logic [1:0] dataBits,
  input  logic       parityEn,
  input  logic       parityOdd,
  input  logic       lineIn,
  output logic       pushValid,
  output logic [7:0] pushData,
  output logic       pushParErr,
  output logic       pushFrmErr,
  output logic       pushBreak
);

  localparam int DW = 8;
  localparam int IW = $clog2(DW);

  logic          lineS;
  logic          dataZero;
  rxStrobe_t     strobe;
  logic [IW-1:0] bitIdx;

  serial_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rstN   (rstN),
    .lineIn (lineIn),
    .lineS  (lineS)
  );

  serial_rx_ctrl #(.OSR(OSR), .DW(DW), .BRK_HI(BRK_HI)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleTick (sampleTick),
    .lineS      (lineS),
    .cmdEnable  (cmdEnable),
    .cmdDisable (cmdDisable),
    .cmdReset   (cmdReset),
    .dataBits   (dataBits),
    .parityEn   (parityEn),
    .dataZero   (dataZero),
    .strobe     (strobe),
    .bitIdx     (bitIdx)
  );

  serial_rx_dpath #(.DW(DW)) u_dpath (
    .clk        (clk),
    .rstN       (rstN),
    .lineS      (lineS),
    .strobe     (strobe),
    .bitIdx     (bitIdx),
    .dataBits   (dataBits),
    .parityEn   (parityEn),
    .parityOdd  (parityOdd),
    .dataZero   (dataZero),
    .pushValid  (pushValid),
    .pushData   (pushData),
    .pushParErr (pushParErr),
    .pushFrmErr (pushFrmErr),
    .pushBreak  (pushBreak)
  );

endmodule

// File: tb/test_serial_rx_top.sv
module test_serial_rx_top;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int BIT_CLKS   = 16 * TICK_DIV;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleTick = 1'b0;
  logic       cmdEnable = 1'b0, cmdDisable = 1'b0, cmdReset = 1'b0;
  logic [1:0] dataBits = 2'd3;
  logic       parityEn = 1'b0, parityOdd = 1'b0;
  logic       lineIn = 1'b1;
  logic       pushValid;
  logic [7:0] pushData;
  logic       pushParErr, pushFrmErr, pushBreak;

  int testsRun = 0;
  int testsFailed = 0;
  int pushCnt = 0;
  int runLen = 0;
  int maxRun = 0;
  int divCnt = 0;
  logic [7:0] capData [0:63];
  logic       capPar  [0:63];
  logic       capFrm  [0:63];
  logic       capBrk  [0:63];

  serial_rx_top i_serial_rx_top (
    .clk(clk), .rstN(rstN), .sampleTick(sampleTick),
    .cmdEnable(cmdEnable), .cmdDisable(cmdDisable), .cmdReset(cmdReset),
    .dataBits(dataBits), .parityEn(parityEn), .parityOdd(parityOdd),
    .lineIn(lineIn), .pushValid(pushValid), .pushData(pushData),
    .pushParErr(pushParErr), .pushFrmErr(pushFrmErr), .pushBreak(pushBreak)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    divCnt     <= (divCnt == TICK_DIV - 1) ? 0 : divCnt + 1;
    sampleTick <= (divCnt == TICK_DIV - 1);
  end

  always @(negedge clk) begin
    if (pushValid) begin
      capData[pushCnt % 64] <= pushData;
      capPar[pushCnt % 64]  <= pushParErr;
      capFrm[pushCnt % 64]  <= pushFrmErr;
      capBrk[pushCnt % 64]  <= pushBreak;
      pushCnt <= pushCnt + 1;
      runLen  <= runLen + 1;
      if (runLen + 1 > maxRun) maxRun <= runLen + 1;
    end else runLen <= 0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bitTime(input logic b);
    @(negedge clk);
    lineIn = b;
    repeat (BIT_CLKS - 1) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input int nb, input bit withPar,
                           input logic parVal, input logic stopVal);
    bitTime(1'b0);
    for (int i = 0; i < nb; i++) bitTime(d[i]);
    if (withPar) bitTime(parVal);
    bitTime(stopVal);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    if (which == 0) cmdEnable = 1'b1;
    if (which == 1) cmdDisable = 1'b1;
    if (which == 2) cmdReset = 1'b1;
    if (which == 3) begin cmdEnable = 1'b1; cmdDisable = 1'b1; end
    @(negedge clk);
    cmdEnable = 1'b0; cmdDisable = 1'b0; cmdReset = 1'b0;
  endtask

  task automatic checkPush(input int idx, input logic [7:0] d, input logic p,
                           input logic f, input logic b, input string req);
    check(capData[idx % 64] == d, req, capData[idx % 64], d);
    check({capPar[idx % 64], capFrm[idx % 64], capBrk[idx % 64]} == {p, f, b},
          req, {capPar[idx % 64], capFrm[idx % 64], capBrk[idx % 64]}, {p, f, b});
  endtask

  task automatic t_reset_state();
    int base;
    check(pushValid == 1'b0, "R1 reset pushValid", pushValid, 0);
    base = pushCnt;
    sendFrame(8'h5A, 8, 0, 0, 1); bitTime(1);
    check(pushCnt == base, "R1 off ignores frame", pushCnt - base, 0);
    pulse(3);
    sendFrame(8'h5A, 8, 0, 0, 1); bitTime(1);
    check(pushCnt == base, "R1 disable beats enable", pushCnt - base, 0);
    pulse(0);
    bitTime(1);
  endtask

  task automatic t_back_to_back();
    int base = pushCnt;
    sendFrame(8'hA5, 8, 0, 0, 1);
    sendFrame(8'h3C, 8, 0, 0, 1);
    bitTime(1);
    check(pushCnt - base == 2, "R5 back to back count", pushCnt - base, 2);
    checkPush(base, 8'hA5, 0, 0, 0, "R3 lsb first A5");
    checkPush(base + 1, 8'h3C, 0, 0, 0, "R5 second frame 3C");
    check(maxRun == 1, "R9 push pulse width", maxRun, 1);
  endtask

  task automatic t_lengths();
    int base = pushCnt;
    dataBits = 2'd0;
    sendFrame(8'hFF, 5, 0, 0, 1); bitTime(1);
    dataBits = 2'd2;
    sendFrame(8'h55, 7, 0, 0, 1); bitTime(1);
    dataBits = 2'd3;
    check(pushCnt - base == 2, "R3 length count", pushCnt - base, 2);
    checkPush(base, 8'h1F, 0, 0, 0, "R3 five bit upper zero");
    checkPush(base + 1, 8'h55, 0, 0, 0, "R3 seven bit");
  endtask

  task automatic t_parity();
    int base = pushCnt;
    parityEn = 1'b1; parityOdd = 1'b0;
    sendFrame(8'h07, 8, 1, 1'b1, 1); bitTime(1);
    parityOdd = 1'b1;
    sendFrame(8'h07, 8, 1, 1'b1, 1); bitTime(1);
    sendFrame(8'h03, 8, 1, 1'b1, 1); bitTime(1);
    parityEn = 1'b0; parityOdd = 1'b0;
    check(pushCnt - base == 3, "R4 parity count", pushCnt - base, 3);
    checkPush(base, 8'h07, 0, 0, 0, "R4 even parity good");
    checkPush(base + 1, 8'h07, 1, 0, 0, "R4 odd parity bad");
    checkPush(base + 2, 8'h03, 0, 0, 0, "R4 odd parity good");
  endtask

  task automatic t_false_start();
    int base = pushCnt;
    @(negedge clk); lineIn = 1'b0;
    repeat (4 * TICK_DIV) @(negedge clk);
    lineIn = 1'b1;
    bitTime(1); bitTime(1); bitTime(1);
    check(pushCnt == base, "R2 glitch rejected", pushCnt - base, 0);
    sendFrame(8'hC3, 8, 0, 0, 1); bitTime(1);
    check(pushCnt - base == 1, "R2 recovery count", pushCnt - base, 1);
    checkPush(base, 8'hC3, 0, 0, 0, "R2 frame after glitch");
  endtask

  task automatic t_framing_resync();
    int base = pushCnt;
    sendFrame(8'h81, 8, 0, 0, 0);
    sendFrame(8'h42, 8, 0, 0, 1);
    bitTime(1);
    check(pushCnt - base == 2, "R6 resync count", pushCnt - base, 2);
    checkPush(base, 8'h81, 0, 1, 0, "R6 framing flag");
    checkPush(base + 1, 8'h42, 0, 0, 0, "R6 resync frame");
  endtask

  task automatic t_break();
    int base = pushCnt;
    sendFrame(8'h00, 8, 0, 0, 0);
    for (int i = 0; i < 12; i++) bitTime(0);
    check(pushCnt - base == 1, "R8 single push on long break", pushCnt - base, 1);
    checkPush(base, 8'h00, 0, 0, 1, "R7 break character");
    bitTime(1);
    sendFrame(8'h5A, 8, 0, 0, 1); bitTime(1);
    check(pushCnt - base == 2, "R8 hunting resumed", pushCnt - base, 2);
    checkPush(base + 1, 8'h5A, 0, 0, 0, "R8 frame after break");
  endtask

  task automatic t_disable_mid();
    int base = pushCnt;
    bitTime(0); bitTime(1); bitTime(1);
    pulse(1);
    bitTime(0); bitTime(0); bitTime(1); bitTime(1); bitTime(0); bitTime(0); bitTime(1);
    bitTime(1);
    check(pushCnt == base, "R10 partial dropped", pushCnt - base, 0);
    pulse(0);
    sendFrame(8'h66, 8, 0, 0, 1); bitTime(1);
    check(pushCnt - base == 1, "R10 after re-enable", pushCnt - base, 1);
    checkPush(base, 8'h66, 0, 0, 0, "R10 frame after re-enable");
  endtask

  task automatic t_cmd_reset();
    int base = pushCnt;
    bitTime(0); bitTime(1);
    pulse(2);
    bitTime(0); bitTime(1); bitTime(0); bitTime(1); bitTime(0); bitTime(1); bitTime(0);
    bitTime(1); bitTime(1);
    sendFrame(8'h99, 8, 0, 0, 1); bitTime(1);
    check(pushCnt == base, "R1 off after cmdReset", pushCnt - base, 0);
    pulse(0);
    sendFrame(8'h99, 8, 0, 0, 1); bitTime(1);
    check(pushCnt - base == 1, "R1 enable after cmdReset", pushCnt - base, 1);
    checkPush(base, 8'h99, 0, 0, 0, "R1 frame after cmdReset");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    t_reset_state();
    t_back_to_back();
    t_lengths();
    t_parity();
    t_false_start();
    t_framing_resync();
    t_break();
    t_disable_mid();
    t_cmd_reset();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule